// File: doc/BRIEF.md
# Packed SIMD Minimum/Maximum Unit

This block takes two packed vectors and returns the lane-wise minimum or maximum of them. Lanes may be signed or unsigned integers of 8, 16 or 32 bits, or IEEE-754 single-precision values. A vector is either 64 or 128 bits wide. The result and its valid strobe appear one clock after an input strobe. When no strobe arrives, the previous result stays on the output.

Float lanes use a total order in which -0.0 sits below +0.0 and the infinities sit at the two ends. NaN inputs follow a selectable policy. A lane can return the canonical quiet NaN 0x7FC00000, or it can return the input NaN with its quiet bit set. The canonical NaN is forced when either the default-NaN control bit or the legacy-mode flag is set. Propagation is possible only when both are clear.

The unit is meant to sit in the execute stage of a vector pipeline. The decoder supplies the element code, the width select and the two floating-point control inputs each time it issues an operation.

Top module: `simd_minmax`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. After reset it is low.
- R2: While `in_valid` is low, `result` holds its last value. After reset it is all zeros.
- R3: Element codes 0, 1 and 2 select signed lanes of 8, 16 and 32 bits, so an 8-bit lane 0xF3 is read as -13. Each lane returns the signed minimum (`op_max`=0) or maximum (`op_max`=1) of the two operands.
- R4: Element codes 3, 4 and 5 select unsigned lanes of 8, 16 and 32 bits. For example, an unsigned 8-bit maximum against 0xF9 returns 0xF9 for every lane value below 0xF9.
- R5: With `wide`=1 all 128 bits are processed. With `wide`=0 only bits 63:0 are processed, which gives 8, 4 or 2 integer lanes or 2 float lanes, and result bits 127:64 are zero.
- R6: Element codes 6 and 7 select 32-bit float lanes compared by numeric value. max(1.0, +inf) = 0x7F800000, max(-inf, 1.0) = 0x3F800000, min(1.0, +inf) = 0x3F800000 and min(-inf, 1.0) = 0xFF800000.
- R7: For float lanes, the maximum of +0.0 and -0.0 is 0x00000000 and the minimum is 0x80000000, in either operand order.
- R8: When `dn_ctrl`=1 or `legacy`=1, any float lane with a NaN operand returns 0x7FC00000. This includes a negative NaN such as 0xFFC00000.
- R9: When `dn_ctrl`=0 and `legacy`=0, a float lane with a NaN operand returns that NaN with fraction bit 22 set. If both operands are NaN, operand A is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_max | input | 1 | 1 = maximum, 0 = minimum |
| elem_kind | input | 3 | Element code: 0..2 signed 8/16/32, 3..5 unsigned 8/16/32, 6..7 float32 |
| wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| dn_ctrl | input | 1 | Default-NaN control bit |
| legacy | input | 1 | Legacy mode; forces default NaN |
| opa | input | 128 | Operand A vector |
| opb | input | 128 | Operand B vector |
| out_valid | output | 1 | Result valid strobe |
| result | output | 128 | Lane-wise result vector |

## Verification
The assertions assume the control inputs are sampled only in a cycle where `in_valid` is high. They also assume that operand lane 0 carries a meaningful float pattern whenever a float element code is issued. The NaN and zero properties look only at that lowest lane and rely on the other lanes being covered elsewhere. The stimulus changes the controls only at falling edges and holds them through each rising edge. It places NaNs, infinities, signed zeros and random values in every lane of both operands. Every element code, both widths and all four combinations of the two NaN controls are exercised.

// File: rtl/simd_minmax.sv
module simd_minmax #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          op_max,
  input  logic [2:0]    elem_kind,
  input  logic          wide,
  input  logic          dn_ctrl,
  input  logic          legacy,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  localparam int NW = DW / 32;
  localparam int HW = DW / 2;
  localparam logic [31:0] CANON_NAN = 32'h7FC0_0000;
  localparam logic [31:0] QUIET_BIT = 32'h0040_0000;

  logic [DW-1:0] res_s [3];
  logic [DW-1:0] res_u [3];
  logic [DW-1:0] res_f;
  logic [DW-1:0] pick, nxt;
  logic          use_dn;

  assign use_dn = dn_ctrl | legacy;

  for (genvar s = 0; s < 3; s++) begin : g_size
    localparam int W = 8 << s;
    for (genvar l = 0; l < DW / W; l++) begin : g_lane
      logic [W-1:0] x, y;
      logic         bs, bu;
      assign x  = opa[l*W +: W];
      assign y  = opb[l*W +: W];
      assign bs = op_max ? ($signed(y) > $signed(x)) : ($signed(y) < $signed(x));
      assign bu = op_max ? (y > x) : (y < x);
      assign res_s[s][l*W +: W] = bs ? y : x;
      assign res_u[s][l*W +: W] = bu ? y : x;
    end
  end

  for (genvar l = 0; l < NW; l++) begin : g_flt
    logic [31:0] x, y, kx, ky, prop;
    logic        xn, yn, tb;
    assign x    = opa[l*32 +: 32];
    assign y    = opb[l*32 +: 32];
    assign xn   = (&x[30:23]) & (|x[22:0]);
    assign yn   = (&y[30:23]) & (|y[22:0]);
    assign kx   = x[31] ? ~x : {1'b1, x[30:0]};
    assign ky   = y[31] ? ~y : {1'b1, y[30:0]};
    assign tb   = op_max ? (ky > kx) : (ky < kx);
    assign prop = xn ? (x | QUIET_BIT) : (y | QUIET_BIT);
    assign res_f[l*32 +: 32] = (xn | yn) ? (use_dn ? CANON_NAN : prop)
                                         : (tb ? y : x);
  end

  always_comb begin
    case (elem_kind)
      3'd0:    pick = res_s[0];
      3'd1:    pick = res_s[1];
      3'd2:    pick = res_s[2];
      3'd3:    pick = res_u[0];
      3'd4:    pick = res_u[1];
      3'd5:    pick = res_u[2];
      default: pick = res_f;
    endcase
  end

  assign nxt = wide ? pick : {{HW{1'b0}}, pick[HW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module simd_minmax_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          op_max,
  input logic [2:0]    elem_kind,
  input logic          wide,
  input logic          dn_ctrl,
  input logic          legacy,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic          out_valid,
  input logic [DW-1:0] result
);
  logic is_f, a0_nan, zero_pair;
  assign is_f      = elem_kind[2] & elem_kind[1];
  assign a0_nan    = (&opa[30:23]) & (|opa[22:0]);
  assign zero_pair = (opa[30:0] == 31'd0) && (opb[30:0] == 31'd0);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[DW-1:DW/2] == '0));
  assert_default_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_f && (dn_ctrl || legacy) && a0_nan) |=> (result[31:0] == 32'h7FC0_0000));
  assert_nan_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_f && !dn_ctrl && !legacy && a0_nan)
      |=> (result[31:0] == ($past(opa[31:0]) | 32'h0040_0000)));
  assert_zero_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_f && op_max && zero_pair) |=> (result[31:0] == {1'b0 , 31'd0}
      || ($past(opa[31]) && $past(opb[31]) && result[31:0] == 32'h8000_0000)));
endmodule

bind simd_minmax simd_minmax_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_max(op_max),
  .elem_kind(elem_kind), .wide(wide), .dn_ctrl(dn_ctrl), .legacy(legacy),
  .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
);

// File: tb/tb_simd_minmax.sv
`timescale 1ns/1ps
module tb_simd_minmax;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, op_max = 1'b0, wide = 1'b0, dn_ctrl = 1'b0, legacy = 1'b0;
  logic [2:0]   elem_kind = 3'd0;
  logic [127:0] opa = '0, opb = '0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0, fails = 0;
  logic         exp_valid = 1'b0;
  logic [127:0] exp_res = '0;

  always #2.5 clk = ~clk;

  simd_minmax dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_max(op_max),
    .elem_kind(elem_kind), .wide(wide), .dn_ctrl(dn_ctrl), .legacy(legacy),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result));

  function automatic bit is_nan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  // numeric less-than for non-NaN floats, with -0 below +0
  function automatic bit f_lt(logic [31:0] p, logic [31:0] q);
    if (p[31] && !q[31]) return 1'b1;
    if (!p[31] && q[31]) return 1'b0;
    if (!p[31]) return p[30:0] < q[30:0];
    return p[30:0] > q[30:0];
  endfunction

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b, bit mx,
                                         int kind, bit wd, bit dn, bit lg);
    logic [127:0] r = '0;
    int bits = wd ? 128 : 64;
    if (kind >= 6) begin
      for (int i = 0; i < bits / 32; i++) begin
        logic [31:0] x = a[i*32 +: 32];
        logic [31:0] y = b[i*32 +: 32];
        logic [31:0] z;
        if (is_nan(x) || is_nan(y)) begin
          if (dn || lg) z = 32'h7FC00000;
          else if (is_nan(x)) z = x | 32'h00400000;
          else z = y | 32'h00400000;
        end else if (mx) z = f_lt(x, y) ? y : x;
        else z = f_lt(y, x) ? y : x;
        r[i*32 +: 32] = z;
      end
    end else begin
      int w = 8 << (kind % 3);
      bit sgn = (kind < 3);
      for (int i = 0; i < bits / w; i++) begin
        longint ua = 0, ub = 0, va, vb, res;
        for (int k = 0; k < w; k++) begin
          ua = ua | (longint'(a[i*w + k]) << k);
          ub = ub | (longint'(b[i*w + k]) << k);
        end
        va = ua; vb = ub;
        if (sgn && a[i*w + w - 1]) va = ua - (64'sd1 <<< w);
        if (sgn && b[i*w + w - 1]) vb = ub - (64'sd1 <<< w);
        if (mx) res = (vb > va) ? ub : ua;
        else    res = (vb < va) ? ub : ua;
        for (int k = 0; k < w; k++) r[i*w + k] = res[k];
      end
    end
    return r;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (out_valid !== exp_valid || result !== exp_res) begin
      fails++;
      $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
               tag, out_valid, result, exp_valid, exp_res);
    end
  endtask

  task automatic apply(string tag, bit mx, int kind, bit wd, bit dn, bit lg,
                       logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_max = mx; elem_kind = kind[2:0]; wide = wd;
    dn_ctrl = dn; legacy = lg; opa = a; opb = b;
    exp_valid = 1'b1;
    exp_res = model(a, b, mx, kind, wd, dn, lg);
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    in_valid = 1'b0; opa = ~opa; op_max = ~op_max;
    exp_valid = 1'b0;
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic expect_lane0(string tag, logic [31:0] v);
    checks++;
    if (result[31:0] !== v) begin
      fails++;
      $display("FAIL %s: lane0=%h expected %h", tag, result[31:0], v);
    end
  endtask

  function automatic logic [127:0] splat(logic [31:0] v);
    return {4{v}};
  endfunction

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] ramp;
    for (int i = 0; i < 16; i++) ramp[i*8 +: 8] = 8'(8'hF0 + i);
    repeat (3) @(negedge clk);
    compare("R1 R2 reset");
    rst_n = 1'b1;
    @(negedge clk); compare("R1 R2 after reset");

    apply("R3 s8 max", 1, 0, 1, 0, 0, ramp, {16{8'hF3}});
    apply("R3 s8 min", 0, 0, 1, 0, 0, ramp, {16{8'hF3}});
    apply("R3 s16 max", 1, 1, 1, 0, 0, ramp, {8{16'hFFF1}});
    apply("R3 s32 min", 0, 2, 1, 0, 0, ramp, splat(32'h8000_0005));
    apply("R4 u8 max", 1, 3, 1, 0, 0, ramp, {16{8'hF9}});
    apply("R4 u16 min", 0, 4, 1, 0, 0, ramp, {8{16'h0FF2}});
    apply("R4 u32 max", 1, 5, 1, 0, 0, ramp, splat(32'h8000_0005));
    apply("R5 narrow s8", 1, 0, 0, 0, 0, ramp, {16{8'h10}});
    apply("R5 narrow float", 0, 6, 0, 0, 0, splat(32'h3F80_0000), splat(32'hC000_0000));
    idle("R2 hold after narrow");
    idle("R2 hold again");
    apply("R6 max 1,+inf", 1, 6, 1, 0, 0, splat(32'h3F80_0000), splat(32'h7F80_0000));
    expect_lane0("R6 max 1,+inf", 32'h7F80_0000);
    apply("R6 max -inf,1", 1, 6, 1, 0, 0, splat(32'hFF80_0000), splat(32'h3F80_0000));
    expect_lane0("R6 max -inf,1", 32'h3F80_0000);
    apply("R6 min 1,+inf", 0, 6, 1, 0, 0, splat(32'h3F80_0000), splat(32'h7F80_0000));
    expect_lane0("R6 min 1,+inf", 32'h3F80_0000);
    apply("R6 min -inf,1", 0, 7, 1, 0, 0, splat(32'hFF80_0000), splat(32'h3F80_0000));
    expect_lane0("R6 min -inf,1", 32'hFF80_0000);
    apply("R6 negatives", 1, 6, 1, 0, 0, splat(32'hC178_0000), splat(32'hC170_0000));
    apply("R7 max +0,-0", 1, 6, 1, 0, 0, splat(32'h0), splat(32'h8000_0000));
    expect_lane0("R7 max +0,-0", 32'h0);
    apply("R7 max -0,+0", 1, 6, 1, 0, 0, splat(32'h8000_0000), splat(32'h0));
    expect_lane0("R7 max -0,+0", 32'h0);
    apply("R7 min +0,-0", 0, 6, 1, 0, 0, splat(32'h0), splat(32'h8000_0000));
    expect_lane0("R7 min +0,-0", 32'h8000_0000);
    apply("R7 min -0,+0", 0, 6, 1, 0, 0, splat(32'h8000_0000), splat(32'h0));
    expect_lane0("R7 min -0,+0", 32'h8000_0000);
    apply("R8 dn -nan", 1, 6, 1, 1, 0, splat(32'hFFC0_0000), splat(32'h3F80_0000));
    expect_lane0("R8 dn -nan", 32'h7FC0_0000);
    apply("R8 legacy -nan", 0, 6, 1, 0, 1, splat(32'hFFC0_0000), splat(32'h3F80_0000));
    expect_lane0("R8 legacy -nan", 32'h7FC0_0000);
    apply("R8 dn nan in b", 1, 6, 1, 1, 1, splat(32'h3F80_0000), splat(32'h7F80_0001));
    expect_lane0("R8 dn nan in b", 32'h7FC0_0000);
    apply("R9 prop -nan", 1, 6, 1, 0, 0, splat(32'hFFC0_0000), splat(32'h3F80_0000));
    expect_lane0("R9 prop -nan", 32'hFFC0_0000);
    apply("R9 quiet snan", 0, 6, 1, 0, 0, splat(32'h3F80_0000), splat(32'h7F80_0001));
    expect_lane0("R9 quiet snan", 32'h7FC0_0001);
    apply("R9 both nan", 1, 6, 1, 0, 0, splat(32'h7F81_2345), splat(32'h7FC0_ABCD));
    expect_lane0("R9 both nan", 32'h7FC1_2345);
    idle("R1 R2 idle");

    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 7);
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      if (kind >= 6 && ($urandom_range(0, 3) == 0)) a[63:32] = 32'h7F80_0000 | ($urandom & 32'h807F_FFFF);
      if (kind >= 6 && ($urandom_range(0, 3) == 0)) b[31:0] = 32'hFF80_0000 | ($urandom & 32'h007F_FFFF);
      if ($urandom_range(0, 5) == 0) idle("R2 random idle");
      apply(kind < 3 ? "R3 random" : (kind < 6 ? "R4 random" : "R6 R8 R9 random"),
            1'($urandom), kind, 1'($urandom), 1'($urandom), 1'($urandom), a, b);
    end
    idle("R1 final idle");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule